// File: doc/BRIEF.md
# Table-Shaped Single-Slope Conversion Controller

This block is the digital core of a single-slope converter whose ramp follows a stored curve instead of a straight line. A sweep counter advances once per clock and indexes a small table. The counter supplies the low index bits and a select input supplies the high bits, so the table holds several separate curves. The table word addressed in each cycle goes out on `dac_code` to an external DAC. The DAC output feeds an analog comparator, which is not part of this block.

The comparator reports high while the ramp is still below the analog input. The block counts the clock cycles in one sweep during which the comparator was high. That count is the pulse width, and it is latched as the conversion result. Every curve must start at zero and must rise monotonically. A linear curve then gives a linear code, and a square-law curve gives a code that grows with the square of the input. A plain write port loads the table.

Top module: `tbl_ramp_adc`

## Requirements
- R1: The sweep counter starts at 0 after reset, steps once per clock and wraps after 2^SWEEP_W counts. `dac_code` is combinationally the table word at index {held select, counter}, with the counter in the low SWEEP_W bits.
- R2: When `tbl_we` is high at a clock edge, `tbl_wdata` is stored at index `tbl_addr`. The high SEL_W bits of `tbl_addr` pick the section and the low SWEEP_W bits pick the entry. Reset clears every entry to zero.
- R3: `result` equals the number of sweep positions whose comparator sample was high. The comparator is sampled through a two-flop synchronizer, and the count covers exactly the positions 0 to 2^SWEEP_W−1 of one sweep.
- R4: If the comparator was high for all 2^SWEEP_W positions of a sweep, `result` saturates at 2^SWEEP_W−1.
- R5: `result_valid` is a one-cycle pulse that appears once every 2^SWEEP_W cycles. It rises at the clock edge where the counter moves from 1 to 2, and `result` changes only at that edge. The first pulse follows the first full sweep after reset.
- R6: The section select is captured only as a sweep begins. Changing `char_sel` during a sweep does not alter that sweep's ramp or its result.
- R7: While `rst_n` is low, `result` is 0, `result_valid` is 0 and `dac_code` is 0.
- R8: With a square-law curve loaded in one section, the result for an input v is the number of that section's entries below v. Different sections give different codes for the same input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low reset |
| cmp_in | input | 1 | Comparator output, asynchronous |
| char_sel | input | SEL_W | Curve section select |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | SEL_W+SWEEP_W | Table write index {section, entry} |
| tbl_wdata | input | CODE_W | Table write data |
| dac_code | output | CODE_W | Ramp code to the DAC |
| result | output | SWEEP_W | Latched pulse-width count |
| result_valid | output | 1 | One-cycle strobe for a new result |

## Verification
`dac_code` is due in the same cycle as the counter value that indexes it. In the negedge right after a valid pulse, the code shown is entry 2 of the held section. The result of a sweep appears two edges after that sweep's last position, which is the synchronizer delay, and it is latched together with the valid strobe. After any change to the input level or the select, the bench therefore discards the next valid pulse and checks the one after it, so that the checked sweep began after the change. The pulse period and the mid-sweep select case are measured by counting negedges between strobes.

// File: rtl/tbl_ramp_adc.sv
module tbl_ramp_adc #(
  parameter int SWEEP_W = 4,
  parameter int SEL_W   = 2,
  parameter int CODE_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmp_in,
  input  logic [SEL_W-1:0]         char_sel,
  input  logic                     tbl_we,
  input  logic [SEL_W+SWEEP_W-1:0] tbl_addr,
  input  logic [CODE_W-1:0]        tbl_wdata,
  output logic [CODE_W-1:0]        dac_code,
  output logic [SWEEP_W-1:0]       result,
  output logic                     result_valid
);
  localparam int ADDR_W = SEL_W + SWEEP_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [SWEEP_W-1:0] LAST = {SWEEP_W{1'b1}};
  localparam logic [SWEEP_W-1:0] TAP  = SWEEP_W'(2);

  logic [CODE_W-1:0]  mem [DEPTH];
  logic [SWEEP_W-1:0] sweep_cnt;
  logic [SWEEP_W-1:0] tap_phase;
  logic [SEL_W-1:0]   sel_hold;
  logic               sync1, sync2, primed;
  logic [SWEEP_W:0]   acc, acc_next;

  assign dac_code  = mem[{sel_hold, sweep_cnt}];
  assign tap_phase = sweep_cnt - TAP;
  assign acc_next  = ((tap_phase == '0) ? '0 : acc) + {{SWEEP_W{1'b0}}, sync2};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (tbl_we) begin
      mem[tbl_addr] <= tbl_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sweep_cnt <= '0;
      sel_hold  <= '0;
      sync1     <= 1'b0;
      sync2     <= 1'b0;
    end else begin
      sweep_cnt <= sweep_cnt + 1'b1;
      if (sweep_cnt == LAST) sel_hold <= char_sel;
      sync1 <= cmp_in;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc          <= '0;
      primed       <= 1'b0;
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      acc          <= acc_next;
      result_valid <= 1'b0;
      if (tap_phase == '0) primed <= 1'b1;
      if (tap_phase == LAST && primed) begin
        result       <= acc_next[SWEEP_W] ? LAST : acc_next[SWEEP_W-1:0];
        result_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tbl_ramp_adc_chk.sv
module tbl_ramp_adc_chk #(
  parameter int SWEEP_W = 4,
  parameter int SEL_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmp_in,
  input logic [SWEEP_W-1:0] result,
  input logic               result_valid,
  input logic [SWEEP_W-1:0] sweep,
  input logic [SEL_W-1:0]   sel_q
);
  localparam int PERIOD = 1 << SWEEP_W;

  int  gap;
  int  hi_run;
  bit  seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap    <= 0;
      hi_run <= 0;
      seen   <= 1'b0;
    end else begin
      gap    <= result_valid ? 0 : gap + 1;
      if (result_valid) seen <= 1'b1;
      hi_run <= cmp_in ? ((hi_run < 4 * PERIOD) ? hi_run + 1 : hi_run) : 0;
    end
  end

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  p_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && seen) |-> (gap == PERIOD - 1));

  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> result_valid);

  p_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && hi_run >= PERIOD + 2) |-> (result == SWEEP_W'(PERIOD - 1)));

  p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep != '0) |-> $stable(sel_q));
endmodule

bind tbl_ramp_adc tbl_ramp_adc_chk #(.SWEEP_W(SWEEP_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .result(result),
  .result_valid(result_valid), .sweep(sweep_cnt), .sel_q(sel_hold)
);

// File: tb/tbl_ramp_adc_test.sv
module tbl_ramp_adc_test;
  localparam int SW = 4, SLW = 2, CW = 8;
  localparam int N = 1 << SW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [SLW-1:0] char_sel = '0;
  logic tbl_we = 1'b0;
  logic [SLW+SW-1:0] tbl_addr = '0;
  logic [CW-1:0] tbl_wdata = '0;
  logic [CW-1:0] dac_code;
  logic [SW-1:0] result;
  logic result_valid;
  int vin = 0;
  logic cmp_in;
  int errors = 0, checks = 0;
  bit done = 0;
  int tbl [4][N];

  assign cmp_in = (vin > int'(dac_code));

  always #10 clk = ~clk;

  tbl_ramp_adc #(.SWEEP_W(SW), .SEL_W(SLW), .CODE_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .char_sel(char_sel),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .dac_code(dac_code), .result(result), .result_valid(result_valid)
  );

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int expect_code(int s, int v);
    int n = 0;
    for (int i = 0; i < N; i++) if (tbl[s][i] < v) n++;
    return (n > N - 1) ? N - 1 : n;
  endfunction

  task automatic wait_valid();
    do @(negedge clk); while (!result_valid);
  endtask

  task automatic convert(int s, int v);
    @(negedge clk);
    char_sel = SLW'(s);
    vin = v;
    wait_valid();
    wait_valid();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < N; i++) begin
      tbl[0][i] = i * 16;
      tbl[1][i] = (i * i * 17) / 15;
      tbl[2][i] = (i < 8) ? 0 : 200;
      tbl[3][i] = 0;
    end

    repeat (3) @(negedge clk);
    check("R7 result", int'(result), 0);
    check("R7 valid", int'(result_valid), 0);
    check("R7 dac", int'(dac_code), 0);
    rst_n = 1'b1;

    check("R2 cleared table", int'(dac_code), 0);
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < N; i++) begin
        @(negedge clk);
        tbl_we = 1'b1;
        tbl_addr = (SLW+SW)'(s * N + i);
        tbl_wdata = CW'(tbl[s][i]);
      end
    @(negedge clk);
    tbl_we = 1'b0;

    // R1 R2: ramp trace over one sweep of section 2
    char_sel = 2'd2;
    wait_valid();
    wait_valid();
    for (int k = 0; k < N; k++) begin
      check("R1 R2 dac trace", int'(dac_code), tbl[2][(k + 2) % N]);
      @(negedge clk);
    end

    // R5: pulse width and period
    wait_valid();
    @(negedge clk);
    check("R5 pulse width", int'(result_valid), 0);
    n = 1;
    while (!result_valid) begin
      @(negedge clk);
      n++;
    end
    check("R5 period", n, N);

    // R3 R4 R8: exhaustive input levels on every section
    for (int s = 0; s < 4; s++)
      for (int v = 0; v < 256; v++) begin
        convert(s, v);
        if (s == 1)      check("R8 square-law result", int'(result), expect_code(s, v));
        else if (s == 3) check("R4 saturated result", int'(result), expect_code(s, v));
        else             check("R3 pulse count", int'(result), expect_code(s, v));
      end
    convert(0, 255);
    check("R4 full-high linear", int'(result), N - 1);
    convert(0, 0);
    check("R3 never high", int'(result), 0);
    convert(0, 100);
    check("R8 linear at 100", int'(result), 7);
    convert(1, 100);
    check("R8 square at 100", int'(result), 10);

    // R6: select changed mid-sweep
    convert(1, 100);
    repeat (5) @(negedge clk);
    char_sel = 2'd3;
    wait_valid();
    check("R6 in-progress sweep", int'(result), expect_code(1, 100));
    wait_valid();
    check("R6 next sweep", int'(result), expect_code(3, 100));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule